// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Detector

This block watches the 32 synchronized input levels of a GPIO port and raises one interrupt request when any pin meets the condition software picked for it. Each pin can stay silent, or it can trigger on a low level, a high level, a rising edge, a falling edge or either edge. Software selects the condition by writing a 4-bit code into that pin's own control word on a simple register bus.

When a pin meets its condition, a sticky flag in a shared status word is set. Software reads the status word to see which pins are pending and clears flags by writing ones to them. The OR of all flags drives the request line through one register stage.

Edges are found by comparing each pin with the level it had at the previous clock edge. In level modes the flag keeps setting for as long as the pin holds the selected level. Clearing a flag therefore does not stick until the pin leaves that level.

Top module: `gpio_irq_detector`

## Requirements
- R1: After reset every condition code and every status flag reads zero, and `irq_out` is low.
- R2: Writing byte address 4×n (n from 0 to 31) stores `bus_wdata[19:16]` as pin n's condition code. A read of that address returns the code in bits 19:16 and zero in every other bit.
- R3: Code 0x0 never sets a flag. Neither does any code outside {0x8, 0x9, 0xA, 0xB, 0xC}.
- R4: Code 0x8 sets pin n's flag at every clock edge where the pin is low. A flag cleared while the pin stays low is set again at once.
- R5: Code 0xC sets the flag at every clock edge where the pin is high.
- R6: Code 0x9 sets the flag at the clock edge where the pin is 1 and was 0 at the previous edge. The flag then stays set until it is cleared, and it is not set again while the pin stays high.
- R7: Code 0xA sets the flag at the clock edge where the pin is 0 and was 1 at the previous edge.
- R8: Code 0xB sets the flag on both the rising edge and the falling edge of the pin.
- R9: The status word is at address 0xA0, and bit n holds pin n's flag. Writing it clears each flag whose data bit is 1 and leaves every flag whose data bit is 0 unchanged.
- R10: If a pin meets its condition in the same cycle as a write that clears its flag, the flag stays set.
- R11: `irq_out` is the OR of all flags, registered. It rises one clock after the first flag sets and falls one clock after the last flag clears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pin_in | input | 32 | Synchronized pin levels |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Shared interrupt request |

## Verification
A pin change driven between clock edges shows up in the status word after the very next rising edge. `irq_out` follows one edge later. The bench therefore reads the status half a period after that first edge and checks `irq_out` both then (still low) and one period later. A control write or a status clear takes effect at the edge inside the write cycle. Each vector lets the pin settle for two edges before clearing, so that a left-over edge cannot set a flag that looks like a result.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    typedef enum logic [3:0] {
        TRIG_NONE = 4'h0,
        TRIG_LOW  = 4'h8,
        TRIG_RISE = 4'h9,
        TRIG_FALL = 4'hA,
        TRIG_BOTH = 4'hB,
        TRIG_HIGH = 4'hC
    } trig_e;

    // Decides whether one pin meets its programmed condition this cycle.
    function automatic logic trig_match(logic [3:0] code, logic cur, logic prev);
        logic m;
        case (code)
            TRIG_LOW:  m = !cur;
            TRIG_HIGH: m = cur;
            TRIG_RISE: m = cur && !prev;
            TRIG_FALL: m = !cur && prev;
            TRIG_BOTH: m = cur ^ prev;
            default:   m = 1'b0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg #(
    parameter int NPINS  = 32,
    parameter int CODE_W = 4,
    localparam int PIN_W = $clog2(NPINS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic [PIN_W-1:0]             cfg_idx,
    input  logic [CODE_W-1:0]            cfg_code,
    output logic [NPINS-1:0][CODE_W-1:0] codes
);

    typedef struct packed {
        logic [NPINS-1:0][CODE_W-1:0] code;
    } cfg_state_t;

    cfg_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (cfg_we) begin
            s_d.code[cfg_idx] = cfg_code;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign codes = s_q.code;

    // R2: a control write lands in the addressed pin's code
    assert_cfg_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (s_q.code[$past(cfg_idx)] == $past(cfg_code)));

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int CODE_W = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NPINS-1:0]             pin_in,
    input  logic [NPINS-1:0][CODE_W-1:0] codes,
    output logic [NPINS-1:0]             hit
);

    typedef struct packed {
        logic [NPINS-1:0] prev;
    } det_state_t;

    det_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.prev = pin_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        assign hit[g] = trig_match(4'(codes[g]), pin_in[g], s_q.prev[g]);

        // R3: an unknown or off code never reports a match
        assert_off_code_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !(codes[g] inside {4'h8, 4'h9, 4'hA, 4'hB, 4'hC}) |-> !hit[g]);

        // R6: a rising-edge match needs the pin low at the previous edge
        assert_rise_needs_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[g] && codes[g] == 4'h9) |-> (pin_in[g] && !s_q.prev[g]));
    end

endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] hit,
    input  logic [NPINS-1:0] clr,
    output logic [NPINS-1:0] flags,
    output logic             irq
);

    typedef struct packed {
        logic [NPINS-1:0] flag;
        logic             irq;
    } st_state_t;

    st_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.flag = (s_q.flag & ~clr) | hit;
        s_d.irq  = |s_q.flag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign flags = s_q.flag;
    assign irq   = s_q.irq;

    // R10: a match always leaves its flag set, even under a clear
    assert_match_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~s_q.flag & $past(hit)) == '0));

    // R9: a flag only rises on a match
    assert_flag_needs_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((s_q.flag & ~$past(s_q.flag) & ~$past(hit)) == '0));

    // R9: a cleared bit without a match is low afterwards
    assert_clear_takes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((s_q.flag & $past(clr & ~hit)) == '0));

    // R11: request line trails the flag word by one cycle
    assert_irq_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (s_q.irq == |$past(s_q.flag)));

endmodule

// File: rtl/gpio_irq_detector.sv
module gpio_irq_detector #(
    parameter int NPINS      = 32,
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32,
    parameter int CODE_W     = 4,
    parameter int CODE_LSB   = 16,
    parameter int STATUS_OFS = 'hA0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPINS-1:0]  pin_in,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_out
);

    localparam int PIN_W = $clog2(NPINS);
    localparam logic [ADDR_W:0]   CFG_SPAN   = (ADDR_W + 1)'(NPINS * 4);
    localparam logic [ADDR_W-1:0] STATUS_ADR = ADDR_W'(STATUS_OFS);

    logic                         sel_cfg;
    logic                         sel_status;
    logic [PIN_W-1:0]             pin_idx;
    logic [NPINS-1:0][CODE_W-1:0] codes;
    logic [NPINS-1:0]             hit;
    logic [NPINS-1:0]             clr;
    logic [NPINS-1:0]             flags;

    assign sel_cfg    = (bus_addr[1:0] == 2'b00) && ({1'b0, bus_addr} < CFG_SPAN);
    assign sel_status = (bus_addr == STATUS_ADR);
    assign pin_idx    = bus_addr[2 +: PIN_W];
    assign clr        = (bus_we && sel_status) ? bus_wdata[NPINS-1:0] : '0;

    gpio_irq_cfg #(
        .NPINS  (NPINS),
        .CODE_W (CODE_W)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (bus_we && sel_cfg),
        .cfg_idx  (pin_idx),
        .cfg_code (bus_wdata[CODE_LSB +: CODE_W]),
        .codes    (codes)
    );

    gpio_irq_detect #(
        .NPINS  (NPINS),
        .CODE_W (CODE_W)
    ) u_detect (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .codes  (codes),
        .hit    (hit)
    );

    gpio_irq_status #(
        .NPINS (NPINS)
    ) u_status (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (hit),
        .clr   (clr),
        .flags (flags),
        .irq   (irq_out)
    );

    always_comb begin
        bus_rdata = '0;
        if (sel_cfg) begin
            bus_rdata[CODE_LSB +: CODE_W] = codes[pin_idx];
        end else if (sel_status) begin
            bus_rdata[NPINS-1:0] = flags;
        end
    end

    // R1: request line is low while nothing is pending after reset
    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !irq_out);

endmodule

// File: tb/tb_gpio_irq_detector.sv
module tb_gpio_irq_detector;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pins = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int checks = 0;
    int fails = 0;

    gpio_irq_detector dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pins),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // {pin[4:0], code[3:0], level before, level after, expected flag}
    localparam logic [11:0] VEC [NVEC] = '{
        {5'd3,  4'h9, 1'b0, 1'b1, 1'b1},  // R6 rising
        {5'd3,  4'h9, 1'b1, 1'b0, 1'b0},  // R6 no flag on fall
        {5'd7,  4'hA, 1'b1, 1'b0, 1'b1},  // R7 falling
        {5'd7,  4'hA, 1'b0, 1'b1, 1'b0},  // R7 no flag on rise
        {5'd12, 4'hB, 1'b0, 1'b1, 1'b1},  // R8 rise
        {5'd12, 4'hB, 1'b1, 1'b0, 1'b1},  // R8 fall
        {5'd0,  4'h8, 1'b1, 1'b0, 1'b1},  // R4 low level
        {5'd0,  4'h8, 1'b1, 1'b1, 1'b0},  // R4 stays high
        {5'd31, 4'hC, 1'b0, 1'b1, 1'b1},  // R5 high level
        {5'd31, 4'hC, 1'b0, 1'b0, 1'b0},  // R5 stays low
        {5'd20, 4'h0, 1'b0, 1'b1, 1'b0},  // R3 off
        {5'd20, 4'h5, 1'b0, 1'b1, 1'b0},  // R3 unlisted
        {5'd20, 4'hF, 1'b1, 1'b0, 1'b0},  // R3 unlisted
        {5'd15, 4'hD, 1'b0, 1'b1, 1'b0}   // R3 unlisted
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_we    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        // R1 reset state
        repeat (3) @(negedge clk);
        bus_read(8'h14, rd);
        check("R1 code in reset", rd, 32'h0);
        bus_read(8'hA0, rd);
        check("R1 status in reset", rd, 32'h0);
        check("R1 irq in reset", {31'b0, irq_out}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1 irq after reset", {31'b0, irq_out}, 32'h0);
        bus_read(8'hA0, rd);
        check("R1 status after reset", rd, 32'h0);

        // R2 readback masks other bits
        bus_write(8'h14, 32'hFFFF_FFFF);
        bus_read(8'h14, rd);
        check("R2 readback pin5", rd, 32'h000F_0000);
        bus_read(8'h18, rd);
        check("R2 neighbour pin6", rd, 32'h0);
        bus_write(8'h14, 32'h0);

        // Vector walk
        for (int v = 0; v < NVEC; v++) begin
            logic [4:0]  p;
            logic [3:0]  code;
            logic        b, a, e;
            logic [31:0] expw;
            {p, code, b, a, e} = VEC[v];
            pins[p] = b;
            bus_write({1'b0, p, 2'b00}, {12'h0, code, 16'h0});
            @(negedge clk);
            @(negedge clk);
            bus_write(8'hA0, 32'hFFFF_FFFF);
            pins[p] = a;
            @(negedge clk);
            expw = 32'(e) << p;
            bus_read(8'hA0, rd);
            check($sformatf("R3-R8 vec%0d status (R%0d)", v,
                  (code == 4'h9) ? 6 : (code == 4'hA) ? 7 : (code == 4'hB) ? 8 :
                  (code == 4'h8) ? 4 : (code == 4'hC) ? 5 : 3), rd, expw);
            check($sformatf("R11 vec%0d irq before", v), {31'b0, irq_out}, 32'h0);
            @(negedge clk);
            check($sformatf("R11 vec%0d irq after", v), {31'b0, irq_out}, {31'b0, e});
            bus_write({1'b0, p, 2'b00}, 32'h0);
            bus_write(8'hA0, 32'hFFFF_FFFF);
        end
        pins = '0;
        @(negedge clk);

        // R4 level re-set after clear
        pins[0] = 1'b1;
        bus_write(8'h00, 32'h0008_0000);
        pins[0] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        bus_write(8'hA0, 32'hFFFF_FFFF);
        bus_read(8'hA0, rd);
        check("R4 flag re-sets while low", rd, 32'h1);
        pins[0] = 1'b1;
        @(negedge clk);
        bus_write(8'h00, 32'h0);
        bus_write(8'hA0, 32'hFFFF_FFFF);
        bus_read(8'hA0, rd);
        check("R4 cleared once released", rd, 32'h0);
        pins[0] = 1'b0;
        @(negedge clk);

        // R10 event and clear in the same cycle
        bus_write(8'h0C, 32'h0009_0000);
        @(negedge clk);
        pins[3] = 1'b1;
        bus_write(8'hA0, 32'hFFFF_FFFF);
        bus_read(8'hA0, rd);
        check("R10 event beats clear", rd, 32'h8);
        bus_write(8'hA0, 32'hFFFF_FFFF);
        bus_read(8'hA0, rd);
        check("R6 no re-set while held high", rd, 32'h0);
        pins[3] = 1'b0;
        @(negedge clk);

        // R9 partial clear
        pins[7] = 1'b1;
        bus_write(8'h1C, 32'h000A_0000);
        @(negedge clk);
        pins[3] = 1'b1;
        pins[7] = 1'b0;
        @(negedge clk);
        bus_read(8'hA0, rd);
        check("R9 two flags", rd, 32'h88);
        bus_write(8'hA0, 32'h0000_0008);
        bus_read(8'hA0, rd);
        check("R9 partial clear keeps bit7", rd, 32'h80);
        check("R11 irq held", {31'b0, irq_out}, 32'h1);
        bus_write(8'hA0, 32'h0000_0080);
        bus_read(8'hA0, rd);
        check("R9 last flag cleared", rd, 32'h0);
        check("R11 irq one cycle late", {31'b0, irq_out}, 32'h1);
        @(negedge clk);
        check("R11 irq falls", {31'b0, irq_out}, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule